// File: doc/BRIEF.md
# GPIO Port Register File

This block is the software-visible register set of one general-purpose I/O port with up to 32 pins. It holds the output-value word and the direction word. Each of these has a write-one-to-set alias and a write-one-to-clear alias, so firmware can change single pins without a read-modify-write. Each pin also has its own configuration word. That word holds the pin direction, an input-buffer disconnect bit, a two-bit level-sense field, and pull and drive-strength fields that are stored but drive nothing here.

The direction has two views: the port-wide direction word and bit 0 of every pin's configuration word. The block keeps them consistent by holding a single copy of each direction bit, which both views read and write. The input-disconnect and sense fields of all pins are collected into port-wide masks. Downstream input, sense and latch logic uses those masks. A one-bit detect-mode register is carried for the same consumer. Access is through a plain word bus: address, write enable and write data, with read data registered one cycle after the address.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the output and direction words are 0 and the detect-mode bit is 0. Every pin configuration word reads 0x2: direction input, input disconnected, sense off. The disconnect mask is all ones and both sense masks are all zeros.
- R2: A write to the output word (0x04) or the direction word (0x14) loads it. Read data is registered, so a read shows the value addressed in the previous cycle.
- R3: A write to the output set alias (0x08) ORs the data into the output word. A read of 0x08 returns the output word.
- R4: A write to the output clear alias (0x0C) clears the output bits that are 1 in the data. A read of 0x0C always returns 0.
- R5: A write to the direction set alias (0x18) ORs the data into the direction word, and a read of 0x18 returns the direction word. A write to the direction clear alias (0x1C) clears the bits that are 1 in the data, and a read of 0x1C returns 0.
- R6: Every change of the direction word, by any of its three addresses, shows in bit 0 of the configuration word of each affected pin.
- R7: A write to the configuration word of pin n (0x200 + 4n) sets direction bit n from data bit 0 and leaves the other direction bits unchanged.
- R8: Configuration bit 1 drives disconnect-mask bit n, where 1 means disconnected. A read of 0x10 returns the pin-level input ANDed with the connected pins.
- R9: The configuration sense field at bits 17:16 is decoded per pin: bit 17 sets the sense-enable mask bit, and bit 16 sets the sense-invert mask bit (1 = sense a low level).
- R10: A write of all zeros to any set or clear alias leaves the output and direction words unchanged.
- R11: Pull (configuration bits 3:2) and drive (bits 10:8) are stored and read back but change no output. All other configuration bits read 0.
- R12: Bit 0 of the detect-mode register at 0x24 is driven on the detect-mode output and reads back.
- R13: Unmapped addresses, including configuration slots for pins at or beyond the pin count, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_level | input | NUM_PINS | Present level of each pin |
| out_level | output | NUM_PINS | Output-value word |
| dir_mask | output | NUM_PINS | Direction word, 1 = output |
| in_disc_mask | output | NUM_PINS | Input disconnect per pin, 1 = disconnected |
| sense_en_mask | output | NUM_PINS | Level sense enabled per pin |
| sense_inv_mask | output | NUM_PINS | Sense low level per pin |
| detect_latched_mode | output | 1 | Detect-mode register bit |

## Verification
The aliases are driven with overlapping patterns on top of a non-zero output word. This separates a true OR or clear from a plain load, and all-zero data shows that a zero write does nothing. Direction is changed alternately through the word, its aliases and single pin configuration writes, with reads of the other view after each change, so a missed mirror shows up. Configuration writes use all four sense codes and mixed pull and drive values, plus set bits outside the fields, to tell the field positions apart. Writes just past the last pin slot check the decode edge.

// File: rtl/gpio_port_regs_pkg.sv
package gpio_port_regs_pkg;

  localparam int unsigned OFS_OUT      = 'h04;
  localparam int unsigned OFS_OUTSET   = 'h08;
  localparam int unsigned OFS_OUTCLR   = 'h0C;
  localparam int unsigned OFS_IN       = 'h10;
  localparam int unsigned OFS_DIR      = 'h14;
  localparam int unsigned OFS_DIRSET   = 'h18;
  localparam int unsigned OFS_DIRCLR   = 'h1C;
  localparam int unsigned OFS_MODE     = 'h24;
  localparam int unsigned OFS_CFG_BASE = 'h200;

  // field positions inside a pin configuration word
  localparam int unsigned CFG_DIR_BIT   = 0;
  localparam int unsigned CFG_DISC_BIT  = 1;
  localparam int unsigned CFG_PULL_LSB  = 2;
  localparam int unsigned CFG_DRIVE_LSB = 8;
  localparam int unsigned CFG_SENSE_LSB = 16;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_OUT, SEL_OUTSET, SEL_OUTCLR, SEL_IN,
    SEL_DIR, SEL_DIRSET, SEL_DIRCLR, SEL_MODE, SEL_CFG
  } reg_sel_e;

  typedef struct packed {
    logic [1:0] sense;
    logic [2:0] drive;
    logic [1:0] pull;
    logic       in_disc;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{sense: 2'b00, drive: 3'b000, pull: 2'b00, in_disc: 1'b1};

  function automatic pin_cfg_t unpack_cfg(input logic [31:0] w);
    pin_cfg_t c;
    c.in_disc = w[CFG_DISC_BIT];
    c.pull    = w[CFG_PULL_LSB +: 2];
    c.drive   = w[CFG_DRIVE_LSB +: 3];
    c.sense   = w[CFG_SENSE_LSB +: 2];
    return c;
  endfunction

  function automatic logic [31:0] pack_cfg(input pin_cfg_t c, input logic dir);
    logic [31:0] w;
    w = '0;
    w[CFG_DIR_BIT]         = dir;
    w[CFG_DISC_BIT]        = c.in_disc;
    w[CFG_PULL_LSB +: 2]   = c.pull;
    w[CFG_DRIVE_LSB +: 3]  = c.drive;
    w[CFG_SENSE_LSB +: 2]  = c.sense;
    return w;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_regs_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int unsigned IDX_W   = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [PIN_W-1:0]  pin_idx
);

  logic [ADDR_W-1:0] rel;
  logic [IDX_W-1:0]  slot;
  logic              in_cfg;

  always_comb begin
    rel    = addr - ADDR_W'(OFS_CFG_BASE);
    slot   = rel[ADDR_W-1:2];
    in_cfg = (addr >= ADDR_W'(OFS_CFG_BASE)) && (addr[1:0] == 2'b00)
             && (slot < IDX_W'(NUM_PINS));
    pin_idx = in_cfg ? slot[PIN_W-1:0] : '0;
    sel = SEL_NONE;
    if (in_cfg) begin
      sel = SEL_CFG;
    end else begin
      case (addr)
        ADDR_W'(OFS_OUT):    sel = SEL_OUT;
        ADDR_W'(OFS_OUTSET): sel = SEL_OUTSET;
        ADDR_W'(OFS_OUTCLR): sel = SEL_OUTCLR;
        ADDR_W'(OFS_IN):     sel = SEL_IN;
        ADDR_W'(OFS_DIR):    sel = SEL_DIR;
        ADDR_W'(OFS_DIRSET): sel = SEL_DIRSET;
        ADDR_W'(OFS_DIRCLR): sel = SEL_DIRCLR;
        ADDR_W'(OFS_MODE):   sel = SEL_MODE;
        default:             sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_out_dir_regs.sv
module gpio_out_dir_regs
  import gpio_port_regs_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  reg_sel_e            sel,
  input  logic [PIN_W-1:0]    pin_idx,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_PINS-1:0] dir_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (we) begin
      case (sel)
        SEL_OUT:    out_q <= wdata;
        SEL_OUTSET: out_q <= out_q | wdata;
        SEL_OUTCLR: out_q <= out_q & ~wdata;
        SEL_DIR:    dir_q <= wdata;
        SEL_DIRSET: dir_q <= dir_q | wdata;
        SEL_DIRCLR: dir_q <= dir_q & ~wdata;
        SEL_CFG:    dir_q[pin_idx] <= wdata[CFG_DIR_BIT];
        default:    ;
      endcase
    end
  end

  AST_OUTSET_ORS: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_OUTSET) |=> (out_q == ($past(out_q) | $past(wdata)))); // R3
  AST_OUTCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_OUTCLR) |=> ((out_q & $past(wdata)) == '0)); // R4
  AST_DIRCLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_DIRCLR) |=> ((dir_q & $past(wdata)) == '0)); // R5
  AST_CFG_DIR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (we && sel == SEL_CFG) |=> ((dir_q ^ $past(dir_q)) & ~(NUM_PINS'(1) << $past(pin_idx))) == '0); // R7
  AST_ZERO_ALIAS_KEEP: assert property (@(posedge clk) disable iff (rst)
    (we && wdata == '0 && (sel == SEL_OUTSET || sel == SEL_OUTCLR || sel == SEL_DIRSET || sel == SEL_DIRCLR))
    |=> ($stable(out_q) && $stable(dir_q))); // R10

endmodule

// File: rtl/gpio_pin_cfg_bank.sv
module gpio_pin_cfg_bank
  import gpio_port_regs_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_cfg,
  input  logic [PIN_W-1:0]    pin_idx,
  input  pin_cfg_t            wcfg,
  output pin_cfg_t            rd_cfg,
  output logic [NUM_PINS-1:0] in_disc_mask,
  output logic [NUM_PINS-1:0] sense_en_mask,
  output logic [NUM_PINS-1:0] sense_inv_mask
);

  pin_cfg_t cfg_q [NUM_PINS];

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[i] <= CFG_RESET;
      end else if (we_cfg && pin_idx == PIN_W'(i)) begin
        cfg_q[i] <= wcfg;
      end
    end
    assign in_disc_mask[i]   = cfg_q[i].in_disc;
    assign sense_en_mask[i]  = cfg_q[i].sense[1];
    assign sense_inv_mask[i] = cfg_q[i].sense[0];
  end

  assign rd_cfg = cfg_q[pin_idx];

  AST_DISC_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (rst)
    we_cfg |=> (in_disc_mask[$past(pin_idx)] == $past(wcfg.in_disc))); // R8
  AST_SENSE_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (rst)
    we_cfg |=> ({sense_en_mask[$past(pin_idx)], sense_inv_mask[$past(pin_idx)]} == $past(wcfg.sense))); // R9

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_regs_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_level,
  output logic [NUM_PINS-1:0] out_level,
  output logic [NUM_PINS-1:0] dir_mask,
  output logic [NUM_PINS-1:0] in_disc_mask,
  output logic [NUM_PINS-1:0] sense_en_mask,
  output logic [NUM_PINS-1:0] sense_inv_mask,
  output logic                detect_latched_mode
);

  localparam int unsigned PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  reg_sel_e         sel;
  logic [PIN_W-1:0] pin_idx;
  pin_cfg_t         rd_cfg;
  logic [31:0]      rd_next;
  logic             mode_q;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) u_dec (
    .addr(bus_addr), .sel(sel), .pin_idx(pin_idx)
  );

  gpio_out_dir_regs #(.NUM_PINS(NUM_PINS)) u_outdir (
    .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .pin_idx(pin_idx),
    .wdata(bus_wdata[NUM_PINS-1:0]), .out_q(out_level), .dir_q(dir_mask)
  );

  gpio_pin_cfg_bank #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk(clk), .rst(rst), .we_cfg(bus_we && sel == SEL_CFG), .pin_idx(pin_idx),
    .wcfg(unpack_cfg(bus_wdata)), .rd_cfg(rd_cfg),
    .in_disc_mask(in_disc_mask), .sense_en_mask(sense_en_mask),
    .sense_inv_mask(sense_inv_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else if (bus_we && sel == SEL_MODE) mode_q <= bus_wdata[0];
  end
  assign detect_latched_mode = mode_q;

  always_comb begin
    case (sel)
      SEL_OUT, SEL_OUTSET: rd_next = 32'(out_level);
      SEL_DIR, SEL_DIRSET: rd_next = 32'(dir_mask);
      SEL_IN:              rd_next = 32'(pin_level & ~in_disc_mask);
      SEL_MODE:            rd_next = {31'b0, mode_q};
      SEL_CFG:             rd_next = pack_cfg(rd_cfg, dir_mask[pin_idx]);
      default:             rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end

  AST_OUTCLR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(OFS_OUTCLR)) |-> (bus_rdata == '0)); // R4
  AST_DIRCLR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_addr) == ADDR_W'(OFS_DIRCLR)) |-> (bus_rdata == '0)); // R5
  AST_MODE_TRACK: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(OFS_MODE)) |=> (detect_latched_mode == $past(bus_wdata[0]))); // R12
  AST_CFG_DIR_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && sel == SEL_CFG) |=> (dir_mask[$past(pin_idx)] == $past(bus_wdata[0]))); // R7

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;

  localparam int unsigned NP = 32;
  localparam int unsigned AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_level = '0;
  logic [NP-1:0] out_level, dir_mask, in_disc_mask, sense_en_mask, sense_inv_mask;
  logic          detect_latched_mode;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  gpio_port_regs #(.NUM_PINS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_level(pin_level), .out_level(out_level), .dir_mask(dir_mask),
    .in_disc_mask(in_disc_mask), .sense_en_mask(sense_en_mask), .sense_inv_mask(sense_inv_mask),
    .detect_latched_mode(detect_latched_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a); bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic int cfg_addr(input int n);
    return 'h200 + 4 * n;
  endfunction

  function automatic logic [31:0] cfg_word(input logic [1:0] sense, input logic [2:0] drv,
                                           input logic [1:0] pull, input logic disc, input logic dir);
    return {14'b0, sense, 5'b0, drv, 4'b0, pull, disc, dir};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 out", 32'(out_level), 0);
    chk("R1 dir", 32'(dir_mask), 0);
    chk("R1 disc", 32'(in_disc_mask), 32'hFFFF_FFFF);
    chk("R1 sense_en", 32'(sense_en_mask), 0);
    chk("R1 sense_inv", 32'(sense_inv_mask), 0);
    chk("R1 mode", 32'(detect_latched_mode), 0);
    rd(cfg_addr(0), d);  chk("R1 cfg0", d, 32'h2);
    rd(cfg_addr(31), d); chk("R1 cfg31", d, 32'h2);
  endtask

  task automatic t_direct();
    logic [31:0] d;
    wr('h04, 32'hA5A5_0F0F);
    chk("R2 out port", 32'(out_level), 32'hA5A5_0F0F);
    rd('h04, d); chk("R2 out read", d, 32'hA5A5_0F0F);
    wr('h14, 32'h0000_00F0);
    rd('h14, d); chk("R2 dir read", d, 32'h0000_00F0);
  endtask

  task automatic t_outset();
    logic [31:0] d;
    wr('h08, 32'h00F0_00F0);
    chk("R3 or", 32'(out_level), 32'hA5F5_0FFF);
    rd('h08, d); chk("R3 read", d, 32'hA5F5_0FFF);
  endtask

  task automatic t_outclr();
    logic [31:0] d;
    wr('h0C, 32'hFF00_000F);
    chk("R4 clear", 32'(out_level), 32'h00F5_0FF0);
    rd('h0C, d); chk("R4 read zero", d, 0);
  endtask

  task automatic t_dir_alias();
    logic [31:0] d;
    wr('h18, 32'h8000_0003);
    chk("R5 dirset", 32'(dir_mask), 32'h8000_00F3);
    rd('h18, d); chk("R5 dirset read", d, 32'h8000_00F3);
    wr('h1C, 32'h0000_0031);
    chk("R5 dirclr", 32'(dir_mask), 32'h8000_00C2);
    rd('h1C, d); chk("R5 dirclr read", d, 0);
  endtask

  task automatic t_mirror();
    logic [31:0] d;
    rd(cfg_addr(31), d); chk("R6 cfg31 dir", d, 32'h3);
    rd(cfg_addr(1), d);  chk("R6 cfg1 dir", d, 32'h3);
    rd(cfg_addr(0), d);  chk("R6 cfg0 dir", d, 32'h2);
    wr('h1C, 32'h8000_0000);
    rd(cfg_addr(31), d); chk("R6 cfg31 after clr", d, 32'h2);
  endtask

  task automatic t_cfg_dir();
    logic [31:0] d;
    wr(cfg_addr(4), 32'h3);
    chk("R7 dir set by cfg", 32'(dir_mask), 32'h0000_00D2);
    wr(cfg_addr(7), 32'h2);
    rd('h14, d); chk("R7 dir clr by cfg", d, 32'h0000_0052);
  endtask

  task automatic t_input();
    logic [31:0] d;
    wr(cfg_addr(3), 32'h0);
    wr(cfg_addr(9), 32'h0);
    chk("R8 disc mask", 32'(in_disc_mask), ~32'h0000_0208);
    pin_level = '1;
    rd('h10, d); chk("R8 in read", d, 32'h0000_0208);
    pin_level = 32'h0000_0200;
    rd('h10, d); chk("R8 in read low", d, 32'h0000_0200);
  endtask

  task automatic t_sense();
    for (int s = 0; s < 4; s++) begin
      wr(cfg_addr(12), cfg_word(2'(s), 3'd0, 2'd0, 1'b1, 1'b0));
      chk("R9 sense_en", 32'(sense_en_mask), (s >= 2) ? 32'h1000 : 0);
      chk("R9 sense_inv", 32'(sense_inv_mask), (s % 2 == 1) ? 32'h1000 : 0);
    end
  endtask

  task automatic t_zero_alias();
    logic [31:0] o, dd;
    o = 32'(out_level); dd = 32'(dir_mask);
    wr('h08, 0); wr('h0C, 0); wr('h18, 0); wr('h1C, 0);
    chk("R10 out kept", 32'(out_level), o);
    chk("R10 dir kept", 32'(dir_mask), dd);
  endtask

  task automatic t_pull_drive();
    logic [31:0] d, o;
    o = 32'(out_level);
    wr(cfg_addr(5), 32'hF000_0000 | cfg_word(2'd0, 3'd5, 2'd3, 1'b1, 1'b0) | 32'h0000_00F0);
    rd(cfg_addr(5), d); chk("R11 readback", d, cfg_word(2'd0, 3'd5, 2'd3, 1'b1, 1'b0));
    chk("R11 out unchanged", 32'(out_level), o);
    chk("R11 dir unchanged", 32'(dir_mask), 32'h0000_0052);
  endtask

  task automatic t_mode();
    logic [31:0] d;
    wr('h24, 32'hFFFF_FFFF);
    chk("R12 mode port", 32'(detect_latched_mode), 1);
    rd('h24, d); chk("R12 mode read", d, 1);
    wr('h24, 0);
    chk("R12 mode clear", 32'(detect_latched_mode), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d, o, dd, c0;
    o = 32'(out_level); dd = 32'(dir_mask);
    rd(cfg_addr(0), c0);
    wr(cfg_addr(32), 32'hFFFF_FFFF);
    wr('h00, 32'hFFFF_FFFF);
    wr('h06, 32'hFFFF_FFFF);
    rd(cfg_addr(32), d); chk("R13 slot past end", d, 0);
    rd('h00, d); chk("R13 zero addr", d, 0);
    chk("R13 out kept", 32'(out_level), o);
    chk("R13 dir kept", 32'(dir_mask), dd);
    rd(cfg_addr(0), d); chk("R13 cfg0 kept", d, c0);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_direct();
    t_outset();
    t_outclr();
    t_dir_alias();
    t_mirror();
    t_cfg_dir();
    t_input();
    t_sense();
    t_zero_alias();
    t_pull_drive();
    t_mode();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule